// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare

This block is a 32-bit down-counting timer placed on a simple word-addressed register bus. A counter steps down once per prescaled tick. The tick comes from one of three external tick-enable inputs and passes through a 12-bit divider. When the counter passes zero it either restarts from a programmed load value or wraps to all-ones and keeps running free.

A compare register is watched on every step. The step that brings the counter onto the compare value sets a sticky flag in the status register. The interrupt output is a masked view of that flag. Software can start the counter from a known value when the timer is switched on, and can rewrite the counter at once through the load register. A self-clearing software-reset bit restores the registers to their reset values but keeps a small set of control bits.

The bus has no wait states. A write takes effect at the next clock edge. Read data is combinational from the address, so a count read returns the counter value of that very cycle.

Top module: `pdt_timer`

## Requirements
- R1: Word offsets 0..4 select control, status, load, compare and count. Offsets 5, 6 and 7 read as zero, and writes to them change no register.
- R2: The control register stores only bits 25:0 of a write, and bits 31:26 read as zero. Control layout: bit0 enable, bit1 start-mode, bit2 compare-interrupt enable, bit3 reload, bit4 software reset, bit5 overwrite, bits 9:6 stored-only, bits 21:10 prescale, bits 23:22 source select, bits 25:24 stored-only.
- R3: The counter moves only on a tick of the selected source while enable is 1. Source 00 selects none, 01 selects tick_a, 10 selects tick_b and 11 selects tick_c. Ticks on unselected inputs have no effect.
- R4: With prescale value N, the counter takes one step per N+1 selected ticks. The divider restarts from zero whenever the timer is disabled or the source is 00.
- R5: Status bit 0 is the compare flag, and the other status bits read zero. Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R6: irq is 1 exactly when the compare flag, the enable bit and the compare-interrupt enable bit are all 1.
- R7: A step from a nonzero count decrements it by one. A step from zero loads the load register if reload is 1, or 0xFFFFFFFF if reload is 0.
- R8: A load-register write with overwrite set makes the count equal the written value in the next cycle. Without overwrite, the count is untouched and the new value is used at the next reload.
- R9: A control write that takes enable from 0 to 1 with start-mode set starts the count from the load register if the written reload bit is 1, or from 0xFFFFFFFF if it is 0. With start-mode clear, the count resumes from its held value.
- R10: A control write with bit 4 set clears status, compare and count, sets load to 0xFFFFFFFF, and keeps bits 0, 1 and 6..9 of the written value while clearing the other control bits. Bit 4 always reads 0. Hard reset gives the same values with control at zero.
- R11: The compare flag is set by a step whose new count equals the compare register. This happens only while enable and compare-interrupt enable are both 1.
- R12: A read at offset 4 returns the live counter value in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_a | input | 1 | Tick enable for source 01 |
| tick_b | input | 1 | Tick enable for source 10 |
| tick_c | input | 1 | Tick enable for source 11 |
| irq | output | 1 | Masked compare interrupt |

## Verification
The bench drives the counter across zero in both reload and free-run modes. A design that mixes up the two modes would reload where it should wrap to all-ones, or the reverse. Load writes are issued with and without overwrite, and enable is raised with and without start-mode. A wrong priority in either case would show up as a count that jumps too early or fails to restart. The bench also runs divided ticks with ticks arriving on unselected inputs, which catches an off-by-one divider or a source decoder that counts the wrong input. It probes flag gating, write-zero and set-versus-clear on status, and the retained control bits after a software reset, so a flag set while masked or a control bit wrongly kept would be seen at the ports.

// File: rtl/pdt_pkg.sv
// Package: shared constants for the periodic down-counter timer.
// Assumes a 32-bit data bus and a 3-bit word address.
package pdt_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int PRE_W    = 12;
    localparam int SRC_W    = 2;
    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_ENMODE = 1;
    localparam int B_IE     = 2;
    localparam int B_RELOAD = 3;
    localparam int B_SWR    = 4;
    localparam int B_OVW    = 5;
    localparam int PRE_LSB  = 10;
    localparam int SRC_LSB  = PRE_LSB + PRE_W;
    localparam int CTRL_W   = SRC_LSB + SRC_W + 2;
    // control bits that survive a software reset: 0, 1, 6..9
    localparam logic [CTRL_W-1:0] RETAIN = CTRL_W'(32'h0000_03C3);
    // word offsets
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
endpackage

// File: rtl/pdt_prescale.sv
// Module: tick source select and divide-by-(N+1) prescaler.
// Assumes tick inputs are single-cycle enables synchronous to clk.
module pdt_prescale
    import pdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SRC_W-1:0] src,
    input  logic [PRE_W-1:0] presc,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             tick_c,
    output logic             ptick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [3:0]       tick_vec;
    logic             sel_tick;
    logic             active;

    // pick the tick input named by the source code
    always_comb begin
        tick_vec = {tick_c, tick_b, tick_a, 1'b0};
        sel_tick = tick_vec[src];
        active   = en && (src != '0);
        ptick    = active && sel_tick && (pre_cnt >= presc);
    end

    // count selected ticks, restart on each output tick or when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            pre_cnt <= '0;
        else if (sel_tick)
            pre_cnt <= ptick ? '0 : pre_cnt + 1'b1;
    end

    // R4: divider restarts after each prescaled tick
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ptick |=> (pre_cnt == '0));
    // R4: a selected tick below the limit advances the divider by one
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel_tick && !ptick) |=> (pre_cnt == $past(pre_cnt) + 1'b1));
    // R3: no source or disabled keeps the divider at zero
    a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (pre_cnt == '0));
endmodule

// File: rtl/pdt_counter.sv
// Module: 32-bit down counter with reload/wrap and compare match.
// Assumes force_ld outranks ptick; match is reported only on a real step.
module pdt_counter
    import pdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptick,
    input  logic              force_ld,
    input  logic [DATA_W-1:0] force_val,
    input  logic              reload_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] cnt,
    output logic              match
);
    logic [DATA_W-1:0] nxt;

    // value after one step: decrement, or reload/wrap from zero
    always_comb begin
        if (cnt == '0)
            nxt = reload_en ? load_val : '1;
        else
            nxt = cnt - 1'b1;
        match = ptick && !force_ld && (nxt == cmp_val);
    end

    // counter register with forced load taking priority over a step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (force_ld)
            cnt <= force_val;
        else if (ptick)
            cnt <= nxt;
    end

    // R7: nonzero step decrements
    a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && !force_ld && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R7: free-run wrap from zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && !force_ld && cnt == '0 && !reload_en) |=> (&cnt));
    // R7: reload from zero
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && !force_ld && cnt == '0 && reload_en) |=> (cnt == $past(load_val)));
    // R3: without a step or a forced load the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptick && !force_ld) |=> $stable(cnt));
    // R8: a forced load lands in the next cycle
    a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
        force_ld |=> (cnt == $past(force_val)));
endmodule

// File: rtl/pdt_regs.sv
// Module: register file, bus decode, compare flag and interrupt mask.
// Assumes one bus access per cycle; read data is combinational on addr.
module pdt_regs
    import pdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              match,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              en,
    output logic              reload_en,
    output logic [SRC_W-1:0]  src,
    output logic [PRE_W-1:0]  presc,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              force_ld,
    output logic [DATA_W-1:0] force_val
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              flag_q;
    logic wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic swr_hit, start_hit, ovw_hit, set_flag;

    // decode writes and derive counter load commands
    always_comb begin
        wr_ctrl   = wr_en && (addr == A_CTRL);
        wr_stat   = wr_en && (addr == A_STAT);
        wr_load   = wr_en && (addr == A_LOAD);
        wr_cmp    = wr_en && (addr == A_CMP);
        swr_hit   = wr_ctrl && wdata[B_SWR];
        start_hit = wr_ctrl && !swr_hit && wdata[B_EN] && !ctrl_q[B_EN]
                    && wdata[B_ENMODE];
        ovw_hit   = wr_load && ctrl_q[B_OVW];
        force_ld  = swr_hit || start_hit || ovw_hit;
        if (swr_hit)
            force_val = '0;
        else if (start_hit)
            force_val = wdata[B_RELOAD] ? load_q : '1;
        else
            force_val = wdata;
        set_flag  = match && ctrl_q[B_EN] && ctrl_q[B_IE];
    end

    // split control fields out for the datapath
    always_comb begin
        en        = ctrl_q[B_EN];
        reload_en = ctrl_q[B_RELOAD];
        src       = ctrl_q[SRC_LSB +: SRC_W];
        presc     = ctrl_q[PRE_LSB +: PRE_W];
        irq       = flag_q && ctrl_q[B_EN] && ctrl_q[B_IE];
    end

    // control register, with retention on software reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= swr_hit ? (wdata[CTRL_W-1:0] & RETAIN) : wdata[CTRL_W-1:0];
    end

    // load and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n || swr_hit) begin
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
        end
    end

    // sticky compare flag: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n || swr_hit)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
        else if (wr_stat && wdata[0])
            flag_q <= 1'b0;
    end

    // read mux, unmapped offsets return zero
    always_comb begin
        case (addr)
            A_CTRL:  rdata = DATA_W'(ctrl_q);
            A_STAT:  rdata = DATA_W'(flag_q);
            A_LOAD:  rdata = load_q;
            A_CMP:   rdata = cmp_q;
            A_CNT:   rdata = cnt;
            default: rdata = '0;
        endcase
    end

    // R5: a clear with no concurrent set empties the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[0] && !match) |=> !flag_q);
    // R10: software reset values and retained control bits
    a_r10_swr: assert property (@(posedge clk) disable iff (!rst_n)
        swr_hit |=> ((&load_q) && cmp_q == '0 && !flag_q
                     && ctrl_q == ($past(wdata[CTRL_W-1:0]) & RETAIN)));
    // R2: a plain control write stores the low bits
    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !swr_hit) |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));
    // R11: the flag only rises after a gated match
    a_r11_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(match && ctrl_q[B_EN] && ctrl_q[B_IE]));
endmodule

// File: rtl/pdt_timer.sv
// Module: top of the periodic down-counter timer with compare.
// Assumes a synchronous active-low reset and ticks synchronous to clk.
module pdt_timer
    import pdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              tick_c,
    output logic              irq
);
    logic              en, reload_en, ptick, match, force_ld;
    logic [SRC_W-1:0]  src;
    logic [PRE_W-1:0]  presc;
    logic [DATA_W-1:0] load_q, cmp_q, cnt, force_val;

    pdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .match(match), .rdata(rdata), .irq(irq), .en(en),
        .reload_en(reload_en), .src(src), .presc(presc), .load_q(load_q),
        .cmp_q(cmp_q), .force_ld(force_ld), .force_val(force_val)
    );

    pdt_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .src(src), .presc(presc),
        .tick_a(tick_a), .tick_b(tick_b), .tick_c(tick_c), .ptick(ptick)
    );

    pdt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .ptick(ptick), .force_ld(force_ld),
        .force_val(force_val), .reload_en(reload_en), .load_val(load_q),
        .cmp_val(cmp_q), .cnt(cnt), .match(match)
    );
endmodule

// File: tb/pdt_timer_tb_top.sv
// Bench: behavioural reference model compared with the DUT on every clock.
module pdt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_a = 1'b0, tick_b = 1'b0, tick_c = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string req = "R10";

    // reference model state
    logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
    logic        m_flag;
    int          m_pre;

    localparam logic [31:0] EN = 32'h1, EMD = 32'h2, IE = 32'h4, RLD = 32'h8,
                            SWR = 32'h10, OVW = 32'h20;

    always #5 clk = ~clk;

    pdt_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_a(tick_a), .tick_b(tick_b),
        .tick_c(tick_c), .irq(irq));

    function automatic logic [31:0] src_f(int n); return 32'(n) << 22; endfunction
    function automatic logic [31:0] pre_f(int n); return 32'(n) << 10; endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return {31'b0, m_flag};
            3'd2: return m_load;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    // advance the model by one clock using pre-edge state
    task automatic m_update(logic w, logic [2:0] a, logic [31:0] d, logic [2:0] tk);
        bit act, sel, pt, frc, swr;
        logic [31:0] fval, nxt;
        int src, presc;
        src = int'(m_ctrl[23:22]);
        presc = int'(m_ctrl[21:10]);
        act = m_ctrl[0] && src != 0;
        sel = (src != 0) && tk[src-1];
        pt = 0;
        if (!act) m_pre = 0;
        else if (sel) begin
            if (m_pre >= presc) begin pt = 1; m_pre = 0; end
            else m_pre++;
        end
        swr = w && a == 0 && d[4];
        frc = 1; fval = 0;
        if (swr) fval = 0;
        else if (w && a == 0 && d[0] && !m_ctrl[0] && d[1]) fval = d[3] ? m_load : 32'hFFFF_FFFF;
        else if (w && a == 2 && m_ctrl[5]) fval = d;
        else frc = 0;
        nxt = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
        if (swr) m_flag = 0;
        else if (pt && !frc && nxt == m_cmp && m_ctrl[0] && m_ctrl[2]) m_flag = 1;
        else if (w && a == 1 && d[0]) m_flag = 0;
        if (frc) m_cnt = fval; else if (pt) m_cnt = nxt;
        if (swr) begin m_load = 32'hFFFF_FFFF; m_cmp = 0; end
        else if (w && a == 2) m_load = d;
        else if (w && a == 3) m_cmp = d;
        if (w && a == 0) m_ctrl = swr ? (d & 32'h0000_03C3) : (d & 32'h03FF_FFFF);
    endtask

    task automatic step(logic w, logic [2:0] a, logic [31:0] d, logic [2:0] tk);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; {tick_c, tick_b, tick_a} = tk;
        #1;
        check(req, rdata, m_read(a));
        check("R6", {31'b0, irq}, {31'b0, m_flag && m_ctrl[0] && m_ctrl[2]});
        @(posedge clk);
        m_update(w, a, d, tk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d); step(1, a, d, 3'b000); endtask
    task automatic idle(int n, logic [2:0] a, logic [2:0] tk);
        for (int i = 0; i < n; i++) step(0, a, 0, tk);
    endtask
    task automatic read_all();
        for (int i = 0; i < 8; i++) step(0, 3'(i), 0, 3'b000);
    endtask

    initial begin
        m_ctrl = 0; m_load = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 0; m_flag = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10 hard reset values
        req = "R10"; read_all();
        @(negedge clk); addr = 3'd2; #1; check("R10 reset load", rdata, 32'hFFFF_FFFF);
        // R2 control width and layout
        req = "R2"; wr(0, 32'hFFFF_FFEF);
        @(negedge clk); wr_en = 0; addr = 0; #1; check("R2 ctrl mask", rdata, 32'h03FF_FFEF);
        idle(2, 0, 3'b000); wr(0, 0);
        // R1 unmapped offsets
        req = "R1"; wr(5, 32'h1234_5678); wr(6, 32'hFFFF_FFFF); wr(7, 32'h5);
        read_all();
        @(negedge clk); addr = 3'd6; #1; check("R1 unmapped read", rdata, 32'h0);
        // R9/R7 start from all-ones then overwrite and free-run wrap
        req = "R9"; wr(0, EN | EMD | OVW | src_f(1)); idle(2, 4, 3'b000);
        req = "R8"; wr(2, 3); idle(2, 4, 3'b000);
        req = "R7"; idle(7, 4, 3'b001);
        req = "R12"; idle(3, 4, 3'b001);
        // R3 unselected ticks ignored
        req = "R3"; idle(5, 4, 3'b110);
        // R7 reload mode
        req = "R7"; wr(0, EN | RLD | OVW | src_f(1)); wr(2, 2); idle(8, 4, 3'b001);
        // R8 load without overwrite
        req = "R8"; wr(0, EN | RLD | src_f(1)); wr(2, 5); idle(3, 4, 3'b000);
        idle(9, 4, 3'b001);
        // R4 prescale by 4 on tick_b, with gaps
        req = "R4"; wr(0, EN | RLD | src_f(2) | pre_f(3)); idle(18, 4, 3'b010);
        for (int i = 0; i < 12; i++) step(0, 4, 0, (i % 3 == 0) ? 3'b000 : 3'b011);
        wr(0, EN | RLD | src_f(3) | pre_f(1)); idle(10, 4, 3'b100);
        // R3 source off
        req = "R3"; wr(0, EN | RLD | src_f(0)); idle(5, 4, 3'b111);
        // R11/R6 compare flag and interrupt
        req = "R11"; wr(0, 0); wr(2, 8); wr(3, 5);
        wr(0, EN | EMD | IE | RLD | src_f(1)); idle(6, 1, 3'b001);
        @(negedge clk); wr_en = 0; addr = 1; {tick_c, tick_b, tick_a} = 0; #1;
        check("R11 flag set", rdata, 32'h1);
        check("R6 irq high", {31'b0, irq}, 32'h1);
        idle(1, 1, 3'b000);
        // R5 status clear semantics
        req = "R5"; wr(1, 0); idle(1, 1, 3'b000);
        req = "R6"; wr(0, EN | RLD | src_f(1)); idle(2, 1, 3'b000);
        wr(0, EN | IE | RLD | src_f(1)); idle(1, 1, 3'b000);
        req = "R5"; wr(1, 1); idle(2, 1, 3'b000);
        // R5 set and clear together: clear at the step landing on compare
        wr(1, 1);
        for (int i = 0; i < 12; i++) step(1, 1, 1, 3'b001);
        idle(2, 1, 3'b000);
        // R11 gating: compare interrupt disabled, flag never set
        req = "R11"; wr(1, 1); wr(0, EN | RLD | src_f(1)); idle(20, 1, 3'b001);
        // R9 resume without start-mode
        req = "R9"; wr(0, RLD | src_f(1)); idle(3, 4, 3'b001);
        wr(0, EN | RLD | src_f(1)); idle(4, 4, 3'b001);
        wr(0, RLD | src_f(1)); wr(0, EN | EMD | src_f(1)); idle(3, 4, 3'b001);
        // R10 software reset with retention
        req = "R10"; wr(0, 32'hFFFF_FFFF); read_all();
        @(negedge clk); addr = 0; #1; check("R10 retained ctrl", rdata, 32'h0000_03C3);
        idle(3, 4, 3'b111); wr(0, 0); read_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule